// File: doc/BRIEF.md
# Partial-Word Load Merge Unit

This block carries out the four load flavours of a big-endian 32-bit integer pipeline: full word, signed byte, left-partial word and right-partial word. A load is launched with a one-cycle start pulse that carries the effective address, the opcode and the current contents of the destination register. The unit always fetches exactly one word over a simple request/grant bus, at the effective address with its two low bits cleared. It then combines the returned bytes with the old register value and reports the merged value together with a one-cycle done pulse.

The legality check uses the aligned word that is actually fetched, not the four bytes the instruction appears to span. As a result, a partial-word load is legal in exactly the places where a byte load at the same address would be legal. An illegal load issues no bus traffic, leaves the register value as it was and flags an address exception. A fetch of the input-port word raises a strobe on the cycle its request is granted, so the attached character device knows that its current character has been taken.

Top module: `ldmerge_unit`

## Requirements
- R1: Every bus request uses address {addr_i[31:2],2'b00}. Each accepted load that raises no exception produces exactly one granted request.
- R2: For op_i=2 (left partial) with k=addr_i[1:0], fetched bytes k..3 fill the result from the most significant byte downward. The lowest k bytes keep old_i. Byte 0 is the word's most significant byte, so result = (word<<8k) | (old_i & (2^(8k)-1)).
- R3: For op_i=3 (right partial) with k=addr_i[1:0], fetched bytes 0..k fill the k+1 least significant result bytes. The upper bytes keep old_i, so result = (word>>8(3-k)) | (old_i with its low k+1 bytes cleared).
- R4: For op_i=0 the result is the fetched word. For op_i=1 the result is byte k of the word, sign-extended to 32 bits.
- R5: For op_i 1, 2 and 3, an exception is raised exactly when the aligned word lies outside every readable region. The readable regions are 0x10000000-0x10FFFFFF, 0x20000000-0x23FFFFFF and the single port word 0x30000000-0x30000003. For example, a left-partial load at 0x23FFFFFD is legal, and one at 0x24000001 is not.
- R6: For op_i=0, an address whose low two bits are non-zero raises an exception even when the word is readable.
- R7: On an exception, exc_o and done_o are high in the first cycle after the start edge. result_o equals old_i. No request is issued and in_consumed_o stays low.
- R8: in_consumed_o is high for exactly one cycle, the grant cycle, and only when the fetched word is 0x30000000. A left-partial load at 0x30000001 therefore raises the strobe and no exception.
- R9: mem_req_o rises in the cycle after the start edge and holds its address until mem_gnt_i is high. mem_rdata_i is sampled at the edge after the grant edge. done_o is a one-cycle pulse in the cycle after that edge, with exc_o low, which makes the latency 3 cycles plus the grant wait.
- R10: A start pulse while a load is in flight is ignored.
- R11: While rst_ni is low and directly after it is released, mem_req_o, done_o, exc_o and in_consumed_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse for a load |
| op_i | input | 2 | 0 word, 1 signed byte, 2 left partial, 3 right partial |
| addr_i | input | 32 | Effective byte address |
| old_i | input | 32 | Current destination register value |
| mem_req_o | output | 1 | Bus read request |
| mem_addr_o | output | 32 | Word-aligned bus address |
| mem_gnt_i | input | 1 | Bus grant; the request is accepted at the edge where both are high |
| mem_rdata_i | input | 32 | Read data, valid in the cycle after the grant |
| in_consumed_o | output | 1 | Input-port word fetched |
| done_o | output | 1 | Result valid pulse |
| result_o | output | 32 | Merged destination value |
| exc_o | output | 1 | Address exception, valid with done_o |

## Verification
An exception result is due in the first cycle after the start edge. A legal load completes 3 cycles after the start edge when the grant is immediate, plus one cycle for each cycle the grant is held back. The bench drives its inputs and samples the outputs on the falling edge. It counts falling edges from the start until done_o appears and compares that count with the figure above. It also checks that done_o is low again one cycle later. The grant and the input-port strobe are sampled a short time after the falling edge, so each granted request is counted once with its address.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  typedef enum logic [1:0] {
    OP_WORD  = 2'd0,
    OP_BYTE  = 2'd1,
    OP_LEFT  = 2'd2,
    OP_RIGHT = 2'd3
  } ld_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RESP = 2'd2
  } ld_state_e;
endpackage

// File: rtl/ldm_addr_check.sv
module ldm_addr_check #(
  parameter int          AW        = 32,
  parameter int          OW        = 2,
  parameter logic [31:0] IMEM_BASE = 32'h1000_0000,
  parameter logic [31:0] IMEM_SIZE = 32'h0100_0000,
  parameter logic [31:0] DMEM_BASE = 32'h2000_0000,
  parameter logic [31:0] DMEM_SIZE = 32'h0400_0000,
  parameter logic [31:0] PORT_ADDR = 32'h3000_0000
) (
  input  logic [AW-1:0]  addr_i,
  input  ldm_pkg::ld_op_e op_i,
  output logic [AW-1:0]  word_addr_o,
  output logic           exc_o,
  output logic           port_o
);
  localparam int NREG = 3;

  logic [AW-1:0] base_a [NREG];
  logic [AW-1:0] size_a [NREG];
  logic [NREG-1:0] hit;
  logic misalign;

  assign base_a[0] = AW'(IMEM_BASE);
  assign size_a[0] = AW'(IMEM_SIZE);
  assign base_a[1] = AW'(DMEM_BASE);
  assign size_a[1] = AW'(DMEM_SIZE);
  assign base_a[2] = AW'(PORT_ADDR);
  assign size_a[2] = AW'(1 << OW);

  assign word_addr_o = {addr_i[AW-1:OW], {OW{1'b0}}};

  // region test on the fetched word only
  for (genvar r = 0; r < NREG; r++) begin : g_region
    logic [AW-1:0] rel;
    assign rel    = word_addr_o - base_a[r];
    assign hit[r] = rel < size_a[r];
  end

  assign misalign = (op_i == ldm_pkg::OP_WORD) && (addr_i[OW-1:0] != '0);
  assign exc_o    = ~(|hit) | misalign;
  assign port_o   = hit[2] & ~misalign;
endmodule

// File: rtl/ldm_merge.sv
module ldm_merge #(
  parameter int DW = 32,
  parameter int NB = DW / 8,
  parameter int OW = $clog2(NB)
) (
  input  ldm_pkg::ld_op_e op_i,
  input  logic [OW-1:0]   off_i,
  input  logic [DW-1:0]   word_i,
  input  logic [DW-1:0]   old_i,
  output logic [DW-1:0]   result_o
);
  // lane/byte index 0 is the most significant (big-endian)
  logic [7:0] mb [NB];
  logic [7:0] ob [NB];
  logic [7:0] sel_byte;

  for (genvar j = 0; j < NB; j++) begin : g_split
    assign mb[j] = word_i[DW-1-8*j -: 8];
    assign ob[j] = old_i[DW-1-8*j -: 8];
  end

  assign sel_byte = mb[off_i];

  for (genvar p = 0; p < NB; p++) begin : g_lane
    logic [7:0] lane;
    always_comb begin
      lane = ob[p];
      unique case (op_i)
        ldm_pkg::OP_WORD: lane = mb[p];
        ldm_pkg::OP_BYTE: lane = (p == NB-1) ? sel_byte : {8{sel_byte[7]}};
        ldm_pkg::OP_LEFT: begin
          if (p + int'(off_i) <= NB-1) lane = mb[OW'(p + int'(off_i))];
        end
        ldm_pkg::OP_RIGHT: begin
          if (p >= NB-1-int'(off_i)) lane = mb[OW'(p - (NB-1-int'(off_i)))];
        end
        default: lane = ob[p];
      endcase
    end
    assign result_o[DW-1-8*p -: 8] = lane;
  end
endmodule

// File: rtl/ldm_ctrl.sv
module ldm_ctrl #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  ldm_pkg::ld_op_e op_i,
  input  logic [OW-1:0]   off_i,
  input  logic [AW-1:0]   word_addr_i,
  input  logic [DW-1:0]   old_i,
  input  logic            exc_i,
  input  logic            port_i,
  input  logic            gnt_i,
  input  logic [DW-1:0]   merged_i,
  output ldm_pkg::ld_op_e op_q_o,
  output logic [OW-1:0]   off_q_o,
  output logic [DW-1:0]   old_q_o,
  output logic            req_o,
  output logic [AW-1:0]   addr_o,
  output logic            consumed_o,
  output logic            done_o,
  output logic [DW-1:0]   result_o,
  output logic            exc_o
);
  import ldm_pkg::*;

  ld_state_e state_q;
  ld_op_e    op_q;
  logic [OW-1:0] off_q;
  logic [DW-1:0] old_q, res_q;
  logic [AW-1:0] wa_q;
  logic port_q, done_q, exc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_WORD;
      off_q   <= '0;
      old_q   <= '0;
      res_q   <= '0;
      wa_q    <= '0;
      port_q  <= 1'b0;
      done_q  <= 1'b0;
      exc_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            op_q   <= op_i;
            off_q  <= off_i;
            old_q  <= old_i;
            wa_q   <= word_addr_i;
            port_q <= port_i;
            if (exc_i) begin
              done_q <= 1'b1;
              exc_q  <= 1'b1;
              res_q  <= old_i;
            end else begin
              exc_q   <= 1'b0;
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: if (gnt_i) state_q <= ST_RESP;
        ST_RESP: begin
          res_q   <= merged_i;
          exc_q   <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign op_q_o     = op_q;
  assign off_q_o    = off_q;
  assign old_q_o    = old_q;
  assign req_o      = (state_q == ST_REQ);
  assign addr_o     = req_o ? wa_q : '0;
  assign consumed_o = req_o & gnt_i & port_q;
  assign done_o     = done_q;
  assign result_o   = res_q;
  assign exc_o      = exc_q & done_q;
endmodule

// File: rtl/ldmerge_unit.sv
module ldmerge_unit #(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter logic [31:0] IMEM_BASE = 32'h1000_0000,
  parameter logic [31:0] IMEM_SIZE = 32'h0100_0000,
  parameter logic [31:0] DMEM_BASE = 32'h2000_0000,
  parameter logic [31:0] DMEM_SIZE = 32'h0400_0000,
  parameter logic [31:0] PORT_ADDR = 32'h3000_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] old_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_gnt_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          in_consumed_o,
  output logic          done_o,
  output logic [DW-1:0] result_o,
  output logic          exc_o
);
  localparam int NB = DW / 8;
  localparam int OW = $clog2(NB);

  ldm_pkg::ld_op_e op_in, op_q;
  logic [OW-1:0]  off_q;
  logic [DW-1:0]  old_q, merged;
  logic [AW-1:0]  word_addr;
  logic           chk_exc, chk_port;

  assign op_in = ldm_pkg::ld_op_e'(op_i);

  ldm_addr_check #(
    .AW(AW), .OW(OW),
    .IMEM_BASE(IMEM_BASE), .IMEM_SIZE(IMEM_SIZE),
    .DMEM_BASE(DMEM_BASE), .DMEM_SIZE(DMEM_SIZE),
    .PORT_ADDR(PORT_ADDR)
  ) u_chk_addr (
    .addr_i     (addr_i),
    .op_i       (op_in),
    .word_addr_o(word_addr),
    .exc_o      (chk_exc),
    .port_o     (chk_port)
  );

  ldm_ctrl #(.AW(AW), .DW(DW), .OW(OW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .op_i       (op_in),
    .off_i      (addr_i[OW-1:0]),
    .word_addr_i(word_addr),
    .old_i      (old_i),
    .exc_i      (chk_exc),
    .port_i     (chk_port),
    .gnt_i      (mem_gnt_i),
    .merged_i   (merged),
    .op_q_o     (op_q),
    .off_q_o    (off_q),
    .old_q_o    (old_q),
    .req_o      (mem_req_o),
    .addr_o     (mem_addr_o),
    .consumed_o (in_consumed_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .exc_o      (exc_o)
  );

  ldm_merge #(.DW(DW), .NB(NB), .OW(OW)) u_merge (
    .op_i    (op_q),
    .off_i   (off_q),
    .word_i  (mem_rdata_i),
    .old_i   (old_q),
    .result_o(merged)
  );
endmodule

// File: rtl/ldm_checker.sv
module ldm_checker #(
  parameter int          AW        = 32,
  parameter logic [31:0] PORT_ADDR = 32'h3000_0000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_gnt_i,
  input logic          in_consumed_o,
  input logic          done_o,
  input logic          exc_o
);
  assert_req_aligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  assert_exc_no_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> done_o && !mem_req_o && !in_consumed_o);

  assert_strobe_port_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_consumed_o |-> mem_req_o && mem_gnt_i && mem_addr_o == AW'(PORT_ADDR));

  assert_strobe_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_consumed_o |=> !in_consumed_o);

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_gnt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !exc_o |-> $past(mem_req_o && mem_gnt_i, 2));
endmodule

bind ldmerge_unit ldm_checker #(.AW(AW), .PORT_ADDR(PORT_ADDR)) u_ldm_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_gnt_i    (mem_gnt_i),
  .in_consumed_o(in_consumed_o),
  .done_o       (done_o),
  .exc_o        (exc_o)
);

// File: tb/tb_ldmerge_unit.sv
`timescale 1ns/1ps
module tb_ldmerge_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [31:0] addr_i = '0;
  logic [31:0] old_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_gnt_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        in_consumed_o;
  logic        done_o;
  logic [31:0] result_o;
  logic        exc_o;

  int n_tests = 0;
  int n_fail  = 0;
  int gnt_wait = 0;
  int wcnt = 0;
  int hs_cnt = 0;
  int strb_cnt = 0;
  logic [31:0] hs_addr = '0;

  always #5 clk_i = ~clk_i;

  ldmerge_unit dut (.*);

  // grant responder, updated on the falling edge
  always @(negedge clk_i) begin
    if (!mem_req_o) begin
      mem_gnt_i = 1'b0;
      wcnt = 0;
    end else if (!mem_gnt_i) begin
      if (wcnt >= gnt_wait) mem_gnt_i = 1'b1;
      else wcnt++;
    end
  end

  // monitor after the responder has settled
  always begin
    @(negedge clk_i);
    #2;
    if (in_consumed_o) strb_cnt++;
    if (mem_req_o && mem_gnt_i) begin
      hs_cnt++;
      hs_addr = mem_addr_o;
    end
  end

  initial begin
    #150000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic model_legal(logic [1:0] op, logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    logic ok;
    ok = (w >= 32'h1000_0000 && w <= 32'h10FF_FFFC) ||
         (w >= 32'h2000_0000 && w <= 32'h23FF_FFFC) ||
         (w == 32'h3000_0000);
    if (op == 2'd0 && a[1:0] != 2'b00) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [31:0] model_res(logic [1:0] op, logic [1:0] k,
                                            logic [31:0] w, logic [31:0] old);
    logic [31:0] m;
    case (op)
      2'd0: return w;
      2'd1: return {{24{w[31-8*k]}}, w[31-8*k -: 8]};
      2'd2: begin
        m = (k == 0) ? 32'h0 : ((32'h1 << (8*k)) - 1);
        return (w << (8*k)) | (old & m);
      end
      default: begin
        m = (k == 3) ? 32'h0 : (32'hFFFF_FFFF << (8*(k+1)));
        return (w >> (8*(3-k))) | (old & m);
      end
    endcase
  endfunction

  // one load: drive, wait for done, check result, latency, bus traffic
  task automatic run_load(string req, logic [1:0] op, logic [31:0] a,
                          logic [31:0] old, logic [31:0] word, int wait_c,
                          bit port_exp);
    int cyc = 0;
    int hs0, st0;
    logic legal = model_legal(op, a);
    gnt_wait = wait_c;
    mem_rdata_i = word;
    hs0 = hs_cnt;
    st0 = strb_cnt;
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; addr_i = a; old_i = old;
    do begin
      @(negedge clk_i);
      start_i = 1'b0;
      cyc++;
    end while (!done_o && cyc < 50);
    check({req, " exc"}, 32'(exc_o), 32'(!legal));
    check({req, " result"}, result_o,
          legal ? model_res(op, a[1:0], word, old) : old);
    check({req, " latency"}, 32'(cyc), legal ? 32'(3 + wait_c) : 32'd1);
    check({req, " requests"}, 32'(hs_cnt - hs0), legal ? 32'd1 : 32'd0);
    if (legal) check({req, " bus addr R1"}, hs_addr, {a[31:2], 2'b00});
    check({req, " strobe R8"}, 32'(strb_cnt - st0), 32'(port_exp));
    @(negedge clk_i);
    check({req, " done pulse R9"}, 32'(done_o), 32'd0);
  endtask

  task automatic test_reset();
    rst_ni = 1'b0;
    #1;
    check("R11 req in reset", 32'(mem_req_o), 32'd0);
    check("R11 done in reset", 32'(done_o), 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11 req after reset", 32'(mem_req_o), 32'd0);
    check("R11 done after reset", 32'(done_o), 32'd0);
    check("R11 exc after reset", 32'(exc_o), 32'd0);
    check("R11 strobe after reset", 32'(in_consumed_o), 32'd0);
  endtask

  task automatic test_left();
    for (int k = 0; k < 4; k++)
      run_load("R2 left partial", 2'd2, 32'h2000_0100 + k, 32'h1122_3344,
               32'hAABB_CCDD, 0, 0);
  endtask

  task automatic test_right();
    for (int k = 0; k < 4; k++)
      run_load("R3 right partial", 2'd3, 32'h2000_0200 + k, 32'h1122_3344,
               32'hAABB_CCDD, 0, 0);
  endtask

  task automatic test_word_byte();
    run_load("R4 word", 2'd0, 32'h2000_0010, 32'h0, 32'hDEAD_BEEF, 0, 0);
    run_load("R4 byte neg", 2'd1, 32'h2000_0012, 32'h0, 32'hAABB_CCDD, 0, 0);
    run_load("R4 byte pos", 2'd1, 32'h2000_0011, 32'h0, 32'hAA7B_CCDD, 0, 0);
    run_load("R4 byte imem top", 2'd1, 32'h10FF_FFFF, 32'h0, 32'h0102_0304, 0, 0);
  endtask

  task automatic test_bounds();
    run_load("R5 left at data top", 2'd2, 32'h23FF_FFFD, 32'h5566_7788,
             32'h0A0B_0C0D, 0, 0);
    run_load("R5 right at data top", 2'd3, 32'h23FF_FFFF, 32'h5566_7788,
             32'h0A0B_0C0D, 0, 0);
    run_load("R5 left past data", 2'd2, 32'h2400_0001, 32'h5566_7788,
             32'h0A0B_0C0D, 0, 0);
    run_load("R5 byte past data", 2'd1, 32'h2400_0000, 32'h1234_5678,
             32'h0, 0, 0);
    run_load("R5 left below imem", 2'd2, 32'h0FFF_FFFF, 32'hCAFE_F00D,
             32'h0, 0, 0);
    run_load("R5 byte after port", 2'd1, 32'h3000_0004, 32'h0BAD_0BAD,
             32'h0, 0, 0);
  endtask

  task automatic test_misalign();
    run_load("R6 word misaligned", 2'd0, 32'h2000_0002, 32'h7777_7777,
             32'h1, 0, 0);
    run_load("R6 word aligned top", 2'd0, 32'h23FF_FFFC, 32'h0,
             32'h1357_9BDF, 0, 0);
    run_load("R7 word misaligned port", 2'd0, 32'h3000_0001, 32'h4444_4444,
             32'h41, 0, 0);
  endtask

  task automatic test_port();
    run_load("R8 left partial port", 2'd2, 32'h3000_0001, 32'h9988_7766,
             32'h0000_0041, 0, 1);
    run_load("R8 word port eof", 2'd0, 32'h3000_0000, 32'h0,
             32'hFFFF_FFFF, 2, 1);
  endtask

  task automatic test_stall();
    run_load("R9 grant wait 4", 2'd3, 32'h2000_0301, 32'h1122_3344,
             32'hAABB_CCDD, 4, 0);
  endtask

  task automatic test_busy_start();
    int hs0 = hs_cnt;
    int cyc = 0;
    gnt_wait = 3;
    mem_rdata_i = 32'hAABB_CCDD;
    @(negedge clk_i);
    start_i = 1'b1; op_i = 2'd0; addr_i = 32'h2000_0400; old_i = 32'h0;
    @(negedge clk_i);
    // second start while the first is waiting for grant
    op_i = 2'd2; addr_i = 32'h2400_0001; old_i = 32'h5555_5555;
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 2;
    while (!done_o && cyc < 50) begin
      @(negedge clk_i);
      cyc++;
    end
    check("R10 result of first load", result_o, 32'hAABB_CCDD);
    check("R10 no exception", 32'(exc_o), 32'd0);
    check("R10 one request", 32'(hs_cnt - hs0), 32'd1);
    check("R10 latency", 32'(cyc), 32'd6);
    repeat (3) @(negedge clk_i);
    check("R10 no extra done", 32'(done_o), 32'd0);
    check("R10 no extra request", 32'(hs_cnt - hs0), 32'd1);
  endtask

  initial begin
    test_reset();
    test_word_byte();
    test_left();
    test_right();
    test_bounds();
    test_misalign();
    test_port();
    test_stall();
    test_busy_start();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule